// File: doc/BRIEF.md
# Banked Memory Conflict Serializer

This block sits between a group of processing elements and a memory split into interleaved banks. The processing elements are grouped into warps, each as wide as the number of banks. Each element may have one request in flight. The scheduler serves one warp at a time and takes the warps in rotation. Within the warp being served, requests aimed at different banks leave together in one cycle. Requests that land on the same bank leave one per cycle, and the lower-numbered element goes first.

Each bank is a small register file behind a pipeline of fixed depth. A response, carrying read data or the echo of a write, appears on the port of the element that made the request. It appears exactly `LAT` cycles after the request was dispatched.

Elements drive a one-cycle request pulse while their ready flag is high. They then wait for their response pulse. A warp with nothing pending is passed over at no cost.

Top module: `bank_conflict_serializer`

## Requirements
- R1: Address `a` lives in bank `a mod NBANK` (the low address bits) at row `a div NBANK`. NBANK is a power of two, and two requests conflict exactly when their low bits match.
- R2: During and right after reset, every `req_ready` bit is 1, every `rsp_valid` bit is 0, and every storage word reads as zero.
- R3: A request is taken when `req_valid[p]` and `req_ready[p]` are both high at a clock edge. `req_ready[p]` then stays low until the edge that ends the cycle of that element's response. A `req_valid[p]` raised while `req_ready[p]` is low is ignored: it gives no response and does not change memory.
- R4: All pending requests of the served warp that aim at distinct banks are dispatched in the same cycle.
- R5: Requests of the served warp that share a bank are dispatched one per cycle, in ascending element index.
- R6: Warps are served round-robin. The next warp in rotation is considered only after every pending request of the current warp has been dispatched. After reset the search starts at warp 0.
- R7: A warp with no pending request is skipped without spending a cycle. A request taken at edge `c` can be dispatched in the cycle that follows that edge.
- R8: A response is visible in the cycle `LAT` cycles after its dispatch cycle. A lone request driven in cycle `c` therefore answers in cycle `c+1+LAT`.
- R9: A read returns the word stored at its address. A write returns its own write data and updates the word. Accesses take effect in dispatch order, so a later read in the same warp sees an earlier write.
- R10: Each accepted request produces exactly one response, and that response appears only on the `rsp_valid`/`rsp_data` lane of the element that made it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPE | Per-element request pulse |
| req_write | input | NPE | Per-element operation: 1 write, 0 read |
| req_addr | input | NPE x AW | Per-element word address |
| req_wdata | input | NPE x DW | Per-element write data |
| req_ready | output | NPE | High while the element has no request in flight |
| rsp_valid | output | NPE | Per-element one-cycle completion pulse |
| rsp_data | output | NPE x DW | Read data, or the written data for a write |

## Verification
A wrong rotation pointer or a wrong conflict ordering does not corrupt data. It moves completions. The affected responses arrive early or late by the length of one warp's service, and this is visible in the batch where it happens. Timing of every response is therefore compared to the cycle, not just its data. A dropped pending bit shows as a missing response once its expected cycle has passed. A wrong write or row mapping only shows at the next read of that word, so read-after-write traffic follows every batch of writes, both within a warp and across batches.

// File: rtl/bkser_pkg.sv
package bkser_pkg;

    localparam int unsigned DEF_NPE   = 8;
    localparam int unsigned DEF_NBANK = 4;
    localparam int unsigned DEF_LAT   = 5;
    localparam int unsigned DEF_AW    = 8;
    localparam int unsigned DEF_DW    = 16;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bkser_warp_rr.sv
module bkser_warp_rr #(
    parameter int unsigned NWARP = 2,
    parameter int unsigned WW    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NWARP-1:0] want,
    input  logic             done,
    output logic             sel_valid,
    output logic [WW-1:0]    sel
);
    logic [WW-1:0] ptr_q;

    // First warp with work, searching from the pointer; highest offset first
    // so the smallest offset wins.
    always_comb begin
        sel_valid = 1'b0;
        sel       = ptr_q;
        for (int k = NWARP - 1; k >= 0; k--) begin
            if (want[(int'(ptr_q) + k) % NWARP]) begin
                sel_valid = 1'b1;
                sel       = WW'((int'(ptr_q) + k) % NWARP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (sel_valid && done) begin
            ptr_q <= (int'(sel) == NWARP - 1) ? '0 : WW'(int'(sel) + 1);
        end else if (sel_valid) begin
            ptr_q <= sel;
        end
    end

    // R6: the pointer only moves to the warp being served or its successor
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && !done) |=> (ptr_q == $past(sel)));

endmodule

// File: rtl/bkser_bank_picker.sv
module bkser_bank_picker #(
    parameter int unsigned NLANE = 4,
    parameter int unsigned LW    = 2
) (
    input  logic [NLANE-1:0] cand,
    output logic [NLANE-1:0] grant,
    output logic [LW-1:0]    lane,
    output logic             any
);
    // Lowest candidate lane wins this bank for the cycle.
    always_comb begin
        grant = '0;
        lane  = '0;
        any   = 1'b0;
        for (int i = NLANE - 1; i >= 0; i--) begin
            if (cand[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                lane     = LW'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bkser_bank.sv
module bkser_bank #(
    parameter int unsigned ROWS = 64,
    parameter int unsigned RW   = 6,
    parameter int unsigned DW   = 16,
    parameter int unsigned TW   = 3,
    parameter int unsigned LAT  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_write,
    input  logic [RW-1:0] in_row,
    input  logic [DW-1:0] in_wdata,
    input  logic [TW-1:0] in_tag,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [TW-1:0] out_tag
);
    typedef struct packed {
        logic          v;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
    } stage_t;

    logic [DW-1:0] store_q [ROWS];
    stage_t        pipe_q  [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) store_q[r] <= '0;
            for (int k = 0; k < LAT; k++)  pipe_q[k]  <= '0;
        end else begin
            if (in_valid && in_write) store_q[in_row] <= in_wdata;
            pipe_q[0].v    <= in_valid;
            pipe_q[0].tag  <= in_tag;
            pipe_q[0].data <= in_write ? in_wdata : store_q[in_row];
            for (int k = 1; k < LAT; k++) pipe_q[k] <= pipe_q[k-1];
        end
    end

    assign out_valid = pipe_q[LAT-1].v;
    assign out_data  = pipe_q[LAT-1].data;
    assign out_tag   = pipe_q[LAT-1].tag;

    // R9: a write lands in storage on its dispatch edge
    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_write) |=> (store_q[$past(in_row)] == $past(in_wdata)));

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
    import bkser_pkg::*;
#(
    parameter int unsigned NPE   = DEF_NPE,
    parameter int unsigned NBANK = DEF_NBANK,
    parameter int unsigned LAT   = DEF_LAT,
    parameter int unsigned AW    = DEF_AW,
    parameter int unsigned DW    = DEF_DW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPE-1:0]          req_valid,
    input  logic [NPE-1:0]          req_write,
    input  logic [NPE-1:0][AW-1:0]  req_addr,
    input  logic [NPE-1:0][DW-1:0]  req_wdata,
    output logic [NPE-1:0]          req_ready,
    output logic [NPE-1:0]          rsp_valid,
    output logic [NPE-1:0][DW-1:0]  rsp_data
);
    localparam int unsigned NWARP = NPE / NBANK;
    localparam int unsigned BW    = idx_bits(NBANK);
    localparam int unsigned RW    = AW - BW;
    localparam int unsigned ROWS  = 1 << RW;
    localparam int unsigned TW    = idx_bits(NPE);
    localparam int unsigned WW    = idx_bits(NWARP);

    typedef struct packed {
        logic          v;
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } pend_t;

    pend_t          pend_q [NPE];
    logic [NPE-1:0] busy_q;
    logic [NPE-1:0] accept, disp, pend_v;

    logic [NWARP-1:0] warp_want;
    logic             sel_valid, warp_done;
    logic [WW-1:0]    sel;

    logic [NBANK-1:0] cand  [NBANK];
    logic [NBANK-1:0] grant [NBANK];
    logic [BW-1:0]    lane  [NBANK];
    logic [NBANK-1:0] bank_go;
    logic [NBANK-1:0] lane_pend, lane_grant;
    logic [TW-1:0]    b_tag [NBANK];

    logic [NBANK-1:0] out_v;
    logic [DW-1:0]    out_d [NBANK];
    logic [TW-1:0]    out_t [NBANK];

    assign accept    = req_valid & ~busy_q;
    assign req_ready = ~busy_q;

    for (genvar p = 0; p < NPE; p++) begin : g_pv
        assign pend_v[p] = pend_q[p].v;
    end

    for (genvar w = 0; w < NWARP; w++) begin : g_want
        assign warp_want[w] = |pend_v[w*NBANK +: NBANK];
    end

    bkser_warp_rr #(.NWARP(NWARP), .WW(WW)) u_rr (
        .clk(clk), .rst(rst), .want(warp_want), .done(warp_done),
        .sel_valid(sel_valid), .sel(sel)
    );

    // Sort the served warp's pending lanes by target bank.
    always_comb begin
        for (int b = 0; b < NBANK; b++) cand[b] = '0;
        lane_pend = '0;
        for (int l = 0; l < NBANK; l++) begin
            if (sel_valid && pend_q[int'(sel) * NBANK + l].v) begin
                cand[pend_q[int'(sel) * NBANK + l].addr[BW-1:0]][l] = 1'b1;
                lane_pend[l] = 1'b1;
            end
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bkser_bank_picker #(.NLANE(NBANK), .LW(BW)) u_pick (
            .cand(cand[b]), .grant(grant[b]), .lane(lane[b]), .any(bank_go[b])
        );

        assign b_tag[b] = TW'(int'(sel) * NBANK + int'(lane[b]));

        bkser_bank #(.ROWS(ROWS), .RW(RW), .DW(DW), .TW(TW), .LAT(LAT)) u_bank (
            .clk(clk), .rst(rst),
            .in_valid(bank_go[b]),
            .in_write(pend_q[b_tag[b]].op == OP_WRITE),
            .in_row(pend_q[b_tag[b]].addr[AW-1:BW]),
            .in_wdata(pend_q[b_tag[b]].wdata),
            .in_tag(b_tag[b]),
            .out_valid(out_v[b]), .out_data(out_d[b]), .out_tag(out_t[b])
        );

        // R5: one dispatch per bank per cycle
        a_r5_one_per_bank: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant[b]));
    end

    always_comb begin
        lane_grant = '0;
        for (int b = 0; b < NBANK; b++) lane_grant |= grant[b];
    end

    assign warp_done = ((lane_pend & ~lane_grant) == '0);

    always_comb begin
        disp = '0;
        for (int l = 0; l < NBANK; l++) begin
            if (sel_valid && lane_grant[l]) disp[int'(sel) * NBANK + l] = 1'b1;
        end
    end

    // Route bank outputs to the owning element.
    always_comb begin
        rsp_valid = '0;
        rsp_data  = '0;
        for (int p = 0; p < NPE; p++) begin
            for (int b = 0; b < NBANK; b++) begin
                if (out_v[b] && out_t[b] == TW'(p)) begin
                    rsp_valid[p] = 1'b1;
                    rsp_data[p]  = out_d[b];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPE; p++) pend_q[p] <= '0;
            busy_q <= '0;
        end else begin
            for (int p = 0; p < NPE; p++) begin
                if (accept[p]) begin
                    pend_q[p].v     <= 1'b1;
                    pend_q[p].op    <= op_e'(req_write[p]);
                    pend_q[p].addr  <= req_addr[p];
                    pend_q[p].wdata <= req_wdata[p];
                    busy_q[p]       <= 1'b1;
                end else begin
                    if (disp[p])      pend_q[p].v <= 1'b0;
                    if (rsp_valid[p]) busy_q[p]   <= 1'b0;
                end
            end
        end
    end

    for (genvar p = 0; p < NPE; p++) begin : g_chk
        // R3: a taken request holds the element off on the next cycle
        a_r3_hold_after_accept: assert property (@(posedge clk) disable iff (rst)
            (req_valid[p] && req_ready[p]) |=> !req_ready[p]);
        // R10: a response only reaches an element with a request in flight
        a_r10_rsp_owned: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[p] |-> !req_ready[p]);
    end

    // R7: pending work always moves at least one request per cycle
    a_r7_no_idle_cycle: assert property (@(posedge clk) disable iff (rst)
        (|pend_v) |-> (|bank_go));

    // R6: all dispatches of a cycle come from a single warp
    logic [NWARP-1:0] warp_disp;
    for (genvar w = 0; w < NWARP; w++) begin : g_wd
        assign warp_disp[w] = |disp[w*NBANK +: NBANK];
    end
    a_r6_one_warp: assert property (@(posedge clk) disable iff (rst)
        $onehot0(warp_disp));

endmodule

// File: tb/sim_bank_conflict_serializer.sv
module sim_bank_conflict_serializer;
    localparam int NPE = 8, NBANK = 4, LAT = 5, AW = 8, DW = 16;
    localparam int NWARP = NPE / NBANK;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NPE-1:0]         req_valid = '0, req_write = '0;
    logic [NPE-1:0][AW-1:0] req_addr  = '0;
    logic [NPE-1:0][DW-1:0] req_wdata = '0;
    logic [NPE-1:0]         req_ready, rsp_valid;
    logic [NPE-1:0][DW-1:0] rsp_data;

    bank_conflict_serializer u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          pe;
        int          cyc;
        logic [15:0] data;
        string       rq;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] mdl_mem [256];
    int cyc = 0, tests = 0, fails = 0, rr_next = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each response with the scoreboard entry for its element.
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NPE; p++) begin
                if (rsp_valid[p]) begin
                    int hit;
                    hit = -1;
                    for (int i = 0; i < sb.size(); i++) if (sb[i].pe == p && hit < 0) hit = i;
                    tests++;
                    if (hit < 0) begin
                        fails++;
                        $display("FAIL R10 stray response pe%0d cycle %0d data %h, expected none", p, cyc, rsp_data[p]);
                    end else begin
                        if (sb[hit].cyc != cyc || sb[hit].data != rsp_data[p]) begin
                            fails++;
                            $display("FAIL %s pe%0d: cycle %0d data %h, expected cycle %0d data %h",
                                     sb[hit].rq, p, cyc, rsp_data[p], sb[hit].cyc, sb[hit].data);
                        end
                        sb.delete(hit);
                    end
                end
            end
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc < cyc) begin
                    tests++;
                    fails++;
                    $display("FAIL %s pe%0d: no response by cycle %0d, expected at cycle %0d",
                             sb[i].rq, sb[i].pe, cyc, sb[i].cyc);
                    sb.delete(i);
                end
            end
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
        end
    endtask

    // Driver: predicts dispatch slots from the rotation and conflict rules,
    // pushes expected responses, then drives a one-cycle request pulse.
    task automatic issue(input logic [NPE-1:0] en, input logic [NPE-1:0] we,
                         input int base, input int stride, input int dbase, input string rq);
        int slot[NPE];
        int addr[NPE];
        int total = 0;
        int lastw = -1;
        int c;
        @(negedge clk);
        c = cyc;
        for (int p = 0; p < NPE; p++) addr[p] = (base + stride * p) % 256;
        for (int k = 0; k < NWARP; k++) begin
            int w = (rr_next + k) % NWARP;
            int cnt[NBANK];
            int mx = 0;
            for (int b = 0; b < NBANK; b++) cnt[b] = 0;
            for (int l = 0; l < NBANK; l++) begin
                int p = w * NBANK + l;
                if (en[p]) begin
                    int b = addr[p] % NBANK;   // R1 bank mapping
                    slot[p] = total + cnt[b];
                    cnt[b]++;
                    if (cnt[b] > mx) mx = cnt[b];
                end
            end
            if (mx > 0) begin
                total += mx;
                lastw = w;
            end
        end
        if (lastw >= 0) rr_next = (lastw + 1) % NWARP;
        for (int s = 0; s < total; s++) begin
            for (int p = 0; p < NPE; p++) begin
                if (en[p] && slot[p] == s) begin
                    exp_t e;
                    e.pe = p;
                    e.cyc = c + 1 + s + LAT;
                    e.rq = rq;
                    if (we[p]) begin
                        mdl_mem[addr[p]] = 16'(dbase + p);
                        e.data = 16'(dbase + p);
                    end else begin
                        e.data = mdl_mem[addr[p]];
                    end
                    sb.push_back(e);
                end
            end
        end
        for (int p = 0; p < NPE; p++) begin
            req_addr[p]  = AW'(addr[p]);
            req_wdata[p] = DW'(dbase + p);
        end
        req_write = we;
        req_valid = en;
        @(negedge clk);
        req_valid = '0;
        check((req_ready & en) == '0, "R3 ready drops after accept", int'(req_ready), int'(~en & 8'hFF));
    endtask

    task automatic drain();
        int n = 0;
        while (sb.size() != 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        repeat (8) @(negedge clk);
        check(sb.size() == 0, "R10 all responses returned", sb.size(), 0);
        check(req_ready == '1, "R3 ready restored", int'(req_ready), 8'hFF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl_mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        check(req_ready == '1, "R2 ready after reset", int'(req_ready), 8'hFF);
        check(rsp_valid == '0, "R2 no response after reset", int'(rsp_valid), 0);

        issue(8'hFF, 8'h00, 0, 1, 0, "R2 storage reads zero"); drain();
        issue(8'hFF, 8'hFF, 0, 1, 16'h1100, "R4 contiguous writes"); drain();
        issue(8'hFF, 8'h00, 0, 1, 0, "R9 contiguous reads"); drain();
        issue(8'hFF, 8'hFF, 32, 4, 16'h2200, "R5 stride-4 writes one bank"); drain();
        issue(8'hFF, 8'h00, 32, 4, 0, "R5 stride-4 reads serialized"); drain();
        issue(8'hFF, 8'h00, 1, 3, 0, "R4 stride-3 coprime reads"); drain();
        issue(8'hFF, 8'h00, 2, 2, 0, "R1 stride-2 two-way conflict"); drain();
        issue(8'hF0, 8'h00, 0, 1, 0, "R7 warp0 idle skipped"); drain();
        issue(8'h0F, 8'h00, 4, 1, 0, "R7 warp1 idle skipped"); drain();
        issue(8'hFF, 8'h00, 0, 1, 0, "R6 rotation starts at warp1"); drain();
        issue(8'h0F, 8'h05, 40, 0, 16'h3300, "R9 same-address write then read"); drain();
        issue(8'h08, 8'h00, 9, 0, 0, "R8 lone request latency"); drain();

        // R3: request while busy is ignored
        issue(8'h04, 8'h00, 9, 0, 0, "R3 busy element read");
        req_addr[2]  = 8'd77;
        req_wdata[2] = 16'hDEAD;
        req_write[2] = 1'b1;
        req_valid[2] = 1'b1;
        check(req_ready[2] == 1'b0, "R3 busy while in flight", int'(req_ready[2]), 0);
        @(negedge clk);
        req_valid = '0;
        req_write = '0;
        drain();
        issue(8'h04, 8'h00, 77, 0, 0, "R3 ignored write left memory"); drain();
        issue(8'hFF, 8'h55, 64, 1, 16'h4400, "R9 mixed reads and writes"); drain();
        issue(8'hFF, 8'h00, 64, 1, 0, "R9 readback mixed"); drain();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (!finished && cyc > 20000) begin
            tests++;
            fails++;
            $display("FAIL R8 watchdog: cycle %0d, expected end before %0d", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule